// File: doc/BRIEF.md
# CEC Transmit Frame Stager

This block sits between a host register port and a bit-level CEC line engine. Software loads an initiator address, a destination address, an opcode and up to fourteen operand bytes into staging registers. It then launches the frame, either through a start register that also carries the operand count or, for a header-only poll, directly through the destination register. The block gives the line engine a frame length and a byte-by-index read port. It restarts the engine after each negative acknowledge until the programmed attempt budget is spent. It reports the outcome through write-one-to-clear status bits that drive a single interrupt line through per-source enables.

Wire timing, arbitration and the bus timebase belong to the line engine. The engine is reached through a one-cycle start pulse, a frame length, a byte index/byte pair, and done/nack pulses. A control register holds a self-clearing flush bit that wipes the staged opcode and operands over several cycles. Its retry field sets the attempt budget and later reports which attempt was last made.

Top module: `cecTxStager`

## Requirements
- R1: After reset, every readable register reads 0, engStart is low and irq is low.
- R2: A write to the start register (offset 0x10) with bit 4 set, while idle, raises engStart for exactly one cycle starting the cycle after the write, with engLen = count + 2 (count in bits 3:0). At engIdx 0, engByte is initiator (offset 0x04, bits 3:0) in bits 7:4 and destination (offset 0x08, bits 3:0) in bits 3:0. At engIdx 1 it is the opcode (offset 0x0C), and at engIdx k ≥ 2 it is operand k-2.
- R3: A start count above 14 is treated as 14, so engLen never exceeds 16.
- R4: A write to the destination register with bit 7 set, while idle, stores the address and launches a one-byte frame (engLen = 1) with no opcode or operands.
- R5: While a frame or a flush is in progress, writes to the start, destination, initiator, opcode, operand and control registers are ignored: no new engStart occurs, engLen holds, and stored values are unchanged.
- R6: A nack from the engine outside the start cycle launches a new attempt (engStart the cycle after the nack) until the attempt index equals the retry limit. A nack on that final attempt sets bit 1 of status register 1 (offset 0x18) and ends the frame.
- R7: Control register (offset 0x00) bits 6:4 hold the retry limit, written as attempts minus one. After a control write they read back that limit. After a launch they read the zero-based index of the latest attempt.
- R8: A done pulse from the engine outside the start cycle sets bit 5 of status register 0 (offset 0x14) and ends the frame.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it set.
- R10: irq is high exactly when status0 bit 5 is set with enable0 (offset 0x1C) bit 5, or status1 bit 1 is set with enable1 (offset 0x20) bit 1.
- R11: Writing control bit 7 = 1 while idle starts a flush. Bit 7 reads 1 for 14 cycles, then clears by itself, and afterwards the opcode and all operands read 0.
- R12: Operand i is written and read at offset 0x40 + 4·i, for i from 0 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Host write strobe |
| regAddr | input | 8 | Host byte address |
| regWdata | input | 8 | Host write data |
| regRdata | output | 8 | Host read data for regAddr |
| engStart | output | 1 | One-cycle pulse starting an attempt |
| engLen | output | 5 | Frame length in bytes |
| engIdx | input | 4 | Byte index requested by the engine |
| engByte | output | 8 | Frame byte at engIdx |
| engDone | input | 1 | Attempt acknowledged |
| engNack | input | 1 | Attempt not acknowledged |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default operand capacity of fourteen and the three-bit retry field, so every frame length from header-only up to the clamped sixteen bytes and every attempt budget from one to eight can be reached. The vector walk covers the full eight-attempt exhaustion and the 15-to-14 clamp, and the flush sweeps all fourteen operand slots. The directed part pushes host writes into an in-flight poll frame and into the flush window, to show that they leave both the engine port and the register readback unchanged.

// File: rtl/cecTxPkg.sv
package cecTxPkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int RETRY_W = 3;
  localparam int CNT_W   = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DEST  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_OPC   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_START = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EN0   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_EN1   = 8'h20;

  // Requests decoded from host writes, already gated by busy
  typedef struct packed {
    logic ctrlWr;
    logic flushReq;
    logic goReq;
    logic pollReq;
  } txReqT;

  // Strobes from control to datapath
  typedef struct packed {
    logic busy;
    logic flushing;
    logic wipe;
    logic setDone;
    logic setFail;
  } txStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_ACTIVE
  } txStateT;
endpackage

// File: rtl/cecTxCtrl.sv
module cecTxCtrl
  import cecTxPkg::*;
#(
  parameter int MAX_OPS = 14,
  localparam int LEN_W  = $clog2(MAX_OPS + 3),
  localparam int OPS_W  = $clog2(MAX_OPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  txReqT              req,
  input  logic [CNT_W-1:0]   goCount,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic               engDone,
  input  logic               engNack,
  output logic               engStart,
  output logic [LEN_W-1:0]   engLen,
  output txStrobeT           strb,
  output logic [OPS_W-1:0]   wipeIdx,
  output logic [RETRY_W-1:0] attemptIdx,
  output logic               showAttempts
);
  txStateT state;
  logic [LEN_W-1:0] cntExt;
  logic [LEN_W-1:0] lenGo;
  logic respond;
  logic lastTry;

  assign cntExt  = LEN_W'(goCount);
  assign lenGo   = (cntExt > LEN_W'(MAX_OPS)) ? LEN_W'(MAX_OPS + 2) : cntExt + LEN_W'(2);
  assign respond = (state == ST_ACTIVE) && !engStart;
  assign lastTry = (attemptIdx == retryLimit);

  always_comb begin
    strb.busy     = (state != ST_IDLE);
    strb.flushing = (state == ST_FLUSH);
    strb.wipe     = (state == ST_FLUSH);
    strb.setDone  = respond && engDone;
    strb.setFail  = respond && !engDone && engNack && lastTry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      engStart     <= 1'b0;
      engLen       <= '0;
      wipeIdx      <= '0;
      attemptIdx   <= '0;
      showAttempts <= 1'b0;
    end else begin
      engStart <= 1'b0;
      if (req.ctrlWr) showAttempts <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req.flushReq) begin
            state   <= ST_FLUSH;
            wipeIdx <= '0;
          end else if (req.goReq || req.pollReq) begin
            state        <= ST_ACTIVE;
            engStart     <= 1'b1;
            engLen       <= req.pollReq ? LEN_W'(1) : lenGo;
            attemptIdx   <= '0;
            showAttempts <= 1'b1;
          end
        end
        ST_FLUSH: begin
          if (wipeIdx == OPS_W'(MAX_OPS - 1)) state <= ST_IDLE;
          else wipeIdx <= wipeIdx + OPS_W'(1);
        end
        ST_ACTIVE: begin
          if (respond) begin
            if (engDone) begin
              state <= ST_IDLE;
            end else if (engNack) begin
              if (lastTry) begin
                state <= ST_IDLE;
              end else begin
                attemptIdx <= attemptIdx + RETRY_W'(1);
                engStart   <= 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cecTxData.sv
module cecTxData
  import cecTxPkg::*;
#(
  parameter int MAX_OPS = 14,
  localparam int IDX_W  = $clog2(MAX_OPS + 2),
  localparam int OPS_W  = $clog2(MAX_OPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  txStrobeT           strb,
  input  logic [OPS_W-1:0]   wipeIdx,
  input  logic [RETRY_W-1:0] attemptIdx,
  input  logic               showAttempts,
  output txReqT              req,
  output logic [CNT_W-1:0]   goCount,
  output logic [RETRY_W-1:0] retryLimit,
  input  logic [IDX_W-1:0]   engIdx,
  output logic [DATA_W-1:0]  engByte,
  output logic               statDone,
  output logic               statFail,
  output logic               irq
);
  logic [3:0]        initQ;
  logic [3:0]        destQ;
  logic [DATA_W-1:0] opcodeQ;
  logic [DATA_W-1:0] en0Q;
  logic [DATA_W-1:0] en1Q;
  logic [DATA_W-1:0] oprQ [MAX_OPS];

  logic       wrOpen;
  logic       isOpr;
  logic [3:0] oprIdx;
  logic [DATA_W-1:0] oprRd;
  logic [RETRY_W-1:0] retryShow;

  assign wrOpen = regWr && !strb.busy;
  assign isOpr  = (regAddr[7:6] == 2'b01) && (regAddr[1:0] == 2'b00);
  assign oprIdx = regAddr[5:2];

  always_comb begin
    req.ctrlWr   = wrOpen && (regAddr == OFS_CTRL);
    req.flushReq = req.ctrlWr && regWdata[7];
    req.goReq    = wrOpen && (regAddr == OFS_START) && regWdata[4];
    req.pollReq  = wrOpen && (regAddr == OFS_DEST) && regWdata[7];
  end
  assign goCount = regWdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryLimit <= '0;
      initQ      <= '0;
      destQ      <= '0;
      en0Q       <= '0;
      en1Q       <= '0;
    end else begin
      if (req.ctrlWr) retryLimit <= regWdata[6:4];
      if (wrOpen && regAddr == OFS_INIT) initQ <= regWdata[3:0];
      if (wrOpen && regAddr == OFS_DEST) destQ <= regWdata[3:0];
      if (regWr && regAddr == OFS_EN0) en0Q <= regWdata;
      if (regWr && regAddr == OFS_EN1) en1Q <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) opcodeQ <= '0;
    else if (strb.wipe && wipeIdx == '0) opcodeQ <= '0;
    else if (wrOpen && regAddr == OFS_OPC) opcodeQ <= regWdata;
  end

  for (genvar g = 0; g < MAX_OPS; g++) begin : gOpr
    always_ff @(posedge clk) begin
      if (!rstN) oprQ[g] <= '0;
      else if (strb.wipe && wipeIdx == OPS_W'(g)) oprQ[g] <= '0;
      else if (wrOpen && isOpr && oprIdx == 4'(g)) oprQ[g] <= regWdata;
    end
  end

  // Status bits: a new event wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statDone <= 1'b0;
      statFail <= 1'b0;
    end else begin
      if (strb.setDone) statDone <= 1'b1;
      else if (regWr && regAddr == OFS_STAT0 && regWdata[5]) statDone <= 1'b0;
      if (strb.setFail) statFail <= 1'b1;
      else if (regWr && regAddr == OFS_STAT1 && regWdata[1]) statFail <= 1'b0;
    end
  end

  assign irq = (statDone && en0Q[5]) || (statFail && en1Q[1]);

  always_comb begin
    oprRd = '0;
    for (int k = 0; k < MAX_OPS; k++)
      if (oprIdx == 4'(k)) oprRd = oprQ[k];
  end

  assign retryShow = showAttempts ? attemptIdx : retryLimit;

  always_comb begin
    unique case (regAddr)
      OFS_CTRL:  regRdata = {strb.flushing, retryShow, 4'b0000};
      OFS_INIT:  regRdata = {4'b0000, initQ};
      OFS_DEST:  regRdata = {4'b0000, destQ};
      OFS_OPC:   regRdata = opcodeQ;
      OFS_STAT0: regRdata = {2'b00, statDone, 5'b00000};
      OFS_STAT1: regRdata = {6'b000000, statFail, 1'b0};
      OFS_EN0:   regRdata = en0Q;
      OFS_EN1:   regRdata = en1Q;
      default:   regRdata = isOpr ? oprRd : '0;
    endcase
  end

  always_comb begin
    engByte = '0;
    if (engIdx == '0) engByte = {initQ, destQ};
    else if (engIdx == IDX_W'(1)) engByte = opcodeQ;
    else begin
      for (int k = 0; k < MAX_OPS; k++)
        if (engIdx == IDX_W'(k + 2)) engByte = oprQ[k];
    end
  end
endmodule

// File: rtl/cecTxStager.sv
module cecTxStager
  import cecTxPkg::*;
#(
  parameter int MAX_OPS = 14,
  localparam int LEN_W  = $clog2(MAX_OPS + 3),
  localparam int IDX_W  = $clog2(MAX_OPS + 2),
  localparam int OPS_W  = $clog2(MAX_OPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              engStart,
  output logic [LEN_W-1:0]  engLen,
  input  logic [IDX_W-1:0]  engIdx,
  output logic [DATA_W-1:0] engByte,
  input  logic              engDone,
  input  logic              engNack,
  output logic              irq
);
  txReqT              req;
  txStrobeT           strb;
  logic [CNT_W-1:0]   goCount;
  logic [RETRY_W-1:0] retryLimit;
  logic [OPS_W-1:0]   wipeIdx;
  logic [RETRY_W-1:0] attemptIdx;
  logic               showAttempts;
  logic               statDone;
  logic               statFail;
  logic               busyW;
  logic               flushW;

  assign busyW  = strb.busy;
  assign flushW = strb.flushing;

  cecTxCtrl #(.MAX_OPS(MAX_OPS)) uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .goCount(goCount),
    .retryLimit(retryLimit), .engDone(engDone), .engNack(engNack),
    .engStart(engStart), .engLen(engLen), .strb(strb), .wipeIdx(wipeIdx),
    .attemptIdx(attemptIdx), .showAttempts(showAttempts)
  );

  cecTxData #(.MAX_OPS(MAX_OPS)) uData (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb),
    .wipeIdx(wipeIdx), .attemptIdx(attemptIdx), .showAttempts(showAttempts),
    .req(req), .goCount(goCount), .retryLimit(retryLimit),
    .engIdx(engIdx), .engByte(engByte), .statDone(statDone),
    .statFail(statFail), .irq(irq)
  );
endmodule

// File: rtl/cecTxChecker.sv
module cecTxChecker #(
  parameter int MAX_OPS = 14,
  parameter int LEN_W   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             engStart,
  input logic [LEN_W-1:0] engLen,
  input logic             engDone,
  input logic             engNack,
  input logic             irq,
  input logic             busy,
  input logic             flushing,
  input logic             statDone,
  input logic             statFail
);
  // R2: each launch is a single-cycle pulse
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R3: launched length within one byte and the clamped maximum
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (engLen >= LEN_W'(1) && engLen <= LEN_W'(MAX_OPS + 2)));

  // R5: frame length holds for the whole frame
  a_r5_len_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flushing && !engStart) |-> $stable(engLen));

  // R6: failure status only rises after a nack
  a_r6_fail_after_nack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statFail) |-> $past(engNack));

  // R8: an accepted done sets the success status
  a_r8_done_status: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flushing && !engStart && engDone) |=> statDone);

  // R10: interrupt only with a status bit pending
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statDone || statFail));

  // R11: no launch during a flush
  a_r11_no_start_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushing |-> !engStart);
endmodule

bind cecTxStager cecTxChecker #(.MAX_OPS(MAX_OPS), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rstN(rstN), .engStart(engStart), .engLen(engLen),
  .engDone(engDone), .engNack(engNack), .irq(irq), .busy(busyW),
  .flushing(flushW), .statDone(statDone), .statFail(statFail)
);

// File: tb/tb_cecTxStager.sv
`timescale 1ns/1ps
module tb_cecTxStager;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN;
  logic       regWr;
  logic [7:0] regAddr;
  logic [7:0] regWdata;
  logic [7:0] regRdata;
  logic       engStart;
  logic [4:0] engLen;
  logic [3:0] engIdx;
  logic [7:0] engByte;
  logic       engDone;
  logic       engNack;
  logic       irq;

  cecTxStager dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engStart(engStart),
    .engLen(engLen), .engIdx(engIdx), .engByte(engByte),
    .engDone(engDone), .engNack(engNack), .irq(irq)
  );

  int nChecks = 0;
  int nFails  = 0;

  // fields: count[15:12] limit[10:8] nacks[7:4] ok[0]
  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h2001, 16'h0321, 16'h5230, 16'hE780,
    16'hF111, 16'h7771, 16'h1010
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic byteAt(input logic [3:0] i, output logic [7:0] d);
    engIdx = i;
    #0.5;
    d = engByte;
  endtask

  task automatic pulseNack;
    @(negedge clk); engNack = 1'b1;
    @(negedge clk); engNack = 1'b0;
  endtask

  task automatic pulseDone;
    @(negedge clk); engDone = 1'b1;
    @(negedge clk); engDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [3:0] cnt, eff, nk;
    logic [2:0] lim;
    logic       ok;
    int         n;
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWdata = '0;
    engIdx = '0; engDone = 1'b0; engNack = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h0C, d); check("R1 opcode", d, 0);
    rd(8'h14, d); check("R1 stat0", d, 0);
    check("R1 engStart", engStart, 0);
    check("R1 irq", irq, 0);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      cnt = VEC[v][15:12]; lim = VEC[v][10:8]; nk = VEC[v][7:4]; ok = VEC[v][0];
      eff = (cnt > 4'd14) ? 4'd14 : cnt;
      wr(8'h00, {1'b0, lim, 4'b0000});
      rd(8'h00, d); check("R7 limit", d[6:4], lim);
      wr(8'h04, 8'(v + 1));
      wr(8'h08, 8'h04);
      wr(8'h0C, 8'(8'h30 + v));
      for (int i = 0; i < int'(eff); i++) wr(8'(8'h40 + 4 * i), 8'(8'h80 + i + v));
      wr(8'h10, {3'b000, 1'b1, cnt});
      check("R2 start", engStart, 1);
      check((cnt > 4'd14) ? "R3 clamp len" : "R2 len", engLen, 32'(eff) + 2);
      byteAt(4'd0, d); check("R2 header", d, {4'(v + 1), 4'h4});
      byteAt(4'd1, d); check("R2 opcode byte", d, 8'h30 + v);
      if (eff > 0) begin
        byteAt(eff + 4'd1, d); check("R2 last operand", d, 8'(8'h80 + int'(eff) - 1 + v));
      end
      for (int a = 0; a < int'(nk); a++) begin
        pulseNack;
        check("R6 retry launch", engStart, (a < int'(lim)) ? 1 : 0);
      end
      if (ok) pulseDone;
      rd(8'h14, d); check("R8 done bit", d[5], ok);
      rd(8'h18, d); check("R6 fail bit", d[1], !ok);
      rd(8'h00, d); check("R7 attempt readback", d[6:4], ok ? 3'(nk) : lim);
      wr(8'h14, 8'h20); wr(8'h18, 8'h02);
      rd(8'h14, d); check("R9 clear stat0", d, 0);
      rd(8'h18, d); check("R9 clear stat1", d, 0);
    end

    // R12 operand addressing
    wr(8'h74, 8'h5E);
    rd(8'h74, d); check("R12 operand 13", d, 8'h5E);
    rd(8'h40, d); check("R12 operand 0", d, 8'h86);

    // R4 poll frame
    wr(8'h04, 8'h05);
    wr(8'h08, 8'h8A);
    check("R4 poll start", engStart, 1);
    check("R4 poll len", engLen, 1);
    byteAt(4'd0, d); check("R4 poll header", d, 8'h5A);

    // R5 writes ignored while in flight
    wr(8'h10, 8'h13);
    check("R5 no relaunch", engStart, 0);
    check("R5 len held", engLen, 1);
    wr(8'h0C, 8'h77);
    rd(8'h0C, d); check("R5 opcode held", d, 8'h36);
    pulseDone;

    // R10 / R9 interrupt gating and write-one-to-clear
    check("R10 irq masked", irq, 0);
    wr(8'h1C, 8'h20);
    check("R10 irq done", irq, 1);
    wr(8'h14, 8'h00);
    rd(8'h14, d); check("R9 zero write keeps", d[5], 1);
    wr(8'h14, 8'h20);
    check("R10 irq cleared", irq, 0);
    wr(8'h20, 8'h02);
    wr(8'h00, 8'h00);
    wr(8'h08, 8'h83);
    pulseNack;
    check("R10 irq fail", irq, 1);
    wr(8'h18, 8'h02);
    check("R10 irq fail cleared", irq, 0);

    // R11 flush
    wr(8'h00, 8'h80);
    n = 0;
    rd(8'h00, d);
    while (d[7] && n < 100) begin
      n++;
      wr(8'h10, 8'h12);
      check("R11 no start in flush", engStart, 0);
      rd(8'h00, d);
    end
    check("R11 flush cycles", n, 7);
    wr(8'h00, 8'h80);
    n = 0;
    rd(8'h00, d);
    while (d[7] && n < 100) begin
      n++;
      @(negedge clk);
      rd(8'h00, d);
    end
    check("R11 flush length", n, 14);
    rd(8'h0C, d); check("R11 opcode wiped", d, 0);
    rd(8'h40, d); check("R11 operand 0 wiped", d, 0);
    rd(8'h74, d); check("R11 operand 13 wiped", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule